// File: doc/BRIEF.md
# Error Insertion Request Controller

This block sits between the control registers of a T3/E3 transmitter and its line encoder and framer. It turns control enable bits and an external manual strobe into single-shot requests to corrupt the transmitted stream. There are five error kinds, each with a fixed bit position in every vector port:

- bit 0: bipolar violation
- bit 1: excessive zeros
- bit 2: P-bit parity
- bit 3: C-bit parity
- bit 4: framing-bit error

Each request stays pending until the datapath signals that an insertion opportunity for that kind has arrived. Examples of an opportunity are the start of the next T3 frame for the parity kinds and the next framing bit for the framing kind.

In automatic mode, a rising edge of an enable bit arms one request. In manual mode, every toggle of the asynchronous manual strobe arms one request for each kind whose enable bit is high. Requests that the current line configuration cannot carry are never armed. These are parity kinds in E3 mode, C-bit parity without C-bit framing, and line-code kinds in unipolar mode. A two-bit framing-error type is captured when a framing request is armed and presented alongside it.

Top module: `err_req_ctrl`

## Requirements
- R1: In automatic mode (man_mode=0), a 0-to-1 change of `err_en[i]` sets `pending[i]` at the next rising clock edge, provided kind i is permitted.
- R2: In automatic mode, an enable bit that stays high arms nothing further. The bit must go low and then high again to arm another request.
- R3: In manual mode (man_mode=1), each rising or falling edge of `man_strobe` sets `pending[i]` for every permitted kind whose `err_en[i]` is 1. This happens at the third rising clock edge after the strobe changes. Kinds with `err_en[i]`=0 stay idle. Enable-bit edges arm nothing in manual mode.
- R4: A pending request of kind i remains set until `opp[i]` is high. In that cycle `fire[i]`=1, and `pending[i]` clears at the following edge.
- R5: An arm event for kind i while `pending[i]` is already set, and `opp[i]` is low, is merged: one opportunity clears it, and no second request follows.
- R6: When a framing request (bit 4) is armed, the value of `frm_sel` in that cycle is captured and held on `frm_kind` until the next framing arm.
- R7: With `e3_mode`=1, arm events for bits 2 and 3 are ignored.
- R8: With `cbit_on`=0, arm events for bit 3 are ignored.
- R9: With `unipolar`=1, arm events for bits 0 and 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_en | input | 5 | Per-kind enable bits (bit 0 BPV, 1 EXZ, 2 P parity, 3 C parity, 4 framing) |
| man_mode | input | 1 | 1 selects manual strobe mode |
| man_strobe | input | 1 | Asynchronous manual strobe; each edge is a toggle |
| e3_mode | input | 1 | 1 = E3 line, 0 = T3 line |
| cbit_on | input | 1 | 1 = C-bit parity framing enabled |
| unipolar | input | 1 | 1 = unipolar line interface |
| frm_sel | input | 2 | Framing-error type selector |
| opp | input | 5 | Per-kind insertion-opportunity strobes from the datapath |
| pending | output | 5 | Armed requests awaiting an opportunity |
| fire | output | 5 | Error applied this cycle, per kind |
| frm_kind | output | 2 | Framing-error type captured at arm time |

## Verification
The bench builds the block with its default parameters: five error kinds, a two-flop strobe synchronizer and a two-bit framing selector. It sweeps every kind through all eight combinations of E3 mode, C-bit framing and unipolar, checking arming, hold-without-rearm and clearing against a permit mask computed in the bench. It then toggles the strobe in both directions for all 32 enable masks and checks the three-edge manual latency. Merged re-arms and capture of all four framing selector values are also covered.

// File: rtl/errins_pkg.sv
// Package: shared constants for the error insertion request controller.
// Assumes the five error kinds keep fixed bit positions in every vector.
package errins_pkg;
    localparam int NUM_KINDS = 5;
    localparam int K_BPV  = 0;
    localparam int K_EXZ  = 1;
    localparam int K_PPAR = 2;
    localparam int K_CPAR = 3;
    localparam int K_FRM  = 4;

    typedef logic [NUM_KINDS-1:0] kind_vec_t;
endpackage

// File: rtl/erq_rise_det.sv
// Module: erq_rise_det
// Detects 0-to-1 transitions on a vector of synchronous control bits.
// Assumes the inputs are already in the clk domain.
module erq_rise_det #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] lvl_q;

    // Remember last cycle's level of every bit.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    // A rise is high now and low one cycle ago.
    always_comb rise = lvl & ~lvl_q;
endmodule

// File: rtl/erq_strobe_sync.sv
// Module: erq_strobe_sync
// Brings an asynchronous strobe into clk with STAGES flops and flags
// either edge as a one-cycle toggle pulse.
// Assumes the strobe is low while reset is applied.
module erq_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic toggle
);
    logic [STAGES:0] chain;

    // Shift the strobe through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], strobe};
    end

    // Any difference between the last two stages is a toggle.
    always_comb toggle = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/erq_gate.sv
// Module: erq_gate
// Computes which error kinds the current line configuration can carry.
// Assumes kind bit positions from errins_pkg.
module erq_gate
    import errins_pkg::*;
(
    input  logic      e3_mode,
    input  logic      cbit_on,
    input  logic      unipolar,
    output kind_vec_t permit
);
    // Clear the permit bit of each kind blocked by the mode inputs.
    always_comb begin
        permit = '1;
        if (unipolar) begin
            permit[K_BPV] = 1'b0;
            permit[K_EXZ] = 1'b0;
        end
        if (e3_mode) begin
            permit[K_PPAR] = 1'b0;
            permit[K_CPAR] = 1'b0;
        end
        if (!cbit_on) permit[K_CPAR] = 1'b0;
    end
endmodule

// File: rtl/erq_slot.sv
// Module: erq_slot
// Holds one pending request; arms merge into an existing one, and an
// opportunity clears it while reporting the fire in the same cycle.
// Assumes arm is already gated by mode and permit.
module erq_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic opp,
    output logic pend,
    output logic fire
);
    // Fire whenever a held request meets its opportunity.
    always_comb fire = pend & opp;

    // Set on arm, clear when fired; an arm during a fire re-sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend & ~opp) | arm;
    end
endmodule

// File: rtl/err_req_ctrl.sv
// Module: err_req_ctrl (top)
// Turns enable bits or a manual strobe into single-shot error requests,
// gated by line mode, and holds each until its insertion opportunity.
// Assumes err_en and mode inputs are synchronous; man_strobe may not be.
module err_req_ctrl
    import errins_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_KINDS-1:0] err_en,
    input  logic                 man_mode,
    input  logic                 man_strobe,
    input  logic                 e3_mode,
    input  logic                 cbit_on,
    input  logic                 unipolar,
    input  logic [SEL_W-1:0]     frm_sel,
    input  logic [NUM_KINDS-1:0] opp,
    output logic [NUM_KINDS-1:0] pending,
    output logic [NUM_KINDS-1:0] fire,
    output logic [SEL_W-1:0]     frm_kind
);
    kind_vec_t en_rise;
    kind_vec_t permit;
    kind_vec_t arm;
    logic      tog;

    erq_rise_det #(.W(NUM_KINDS)) u_rise (
        .clk(clk), .rst_n(rst_n), .lvl(err_en), .rise(en_rise)
    );

    erq_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .strobe(man_strobe), .toggle(tog)
    );

    erq_gate u_gate (
        .e3_mode(e3_mode), .cbit_on(cbit_on), .unipolar(unipolar),
        .permit(permit)
    );

    // Choose the arm source by mode, then drop kinds the line cannot carry.
    always_comb begin
        if (man_mode) arm = (tog ? err_en : '0) & permit;
        else          arm = en_rise & permit;
    end

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_slot
        erq_slot u_slot (
            .clk(clk), .rst_n(rst_n), .arm(arm[k]), .opp(opp[k]),
            .pend(pending[k]), .fire(fire[k])
        );
    end

    // Capture the framing-error type when a framing request is armed.
    always_ff @(posedge clk) begin
        if (!rst_n)         frm_kind <= '0;
        else if (arm[K_FRM]) frm_kind <= frm_sel;
    end
endmodule

// File: rtl/err_req_ctrl_chk.sv
// Module: err_req_ctrl_chk
// Property checker for err_req_ctrl, attached with bind.
module err_req_ctrl_chk
    import errins_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_KINDS-1:0] err_en,
    input logic                 man_mode,
    input logic                 e3_mode,
    input logic                 cbit_on,
    input logic                 unipolar,
    input logic [SEL_W-1:0]     frm_sel,
    input logic [NUM_KINDS-1:0] opp,
    input logic [NUM_KINDS-1:0] pending,
    input logic [SEL_W-1:0]     frm_kind
);
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_k
        // R1
        auto_arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pending[k]) && !$past(man_mode)) |-> $past(err_en[k]));
        // R3
        man_arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pending[k]) && $past(man_mode)) |-> $past(err_en[k]));
        // R4
        clear_on_opp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pending[k]) |-> $past(opp[k]));
    end

    // R7
    e3_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pending[K_PPAR]) || $rose(pending[K_CPAR])) |-> !$past(e3_mode));
    // R8
    cbit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending[K_CPAR]) |-> $past(cbit_on));
    // R9
    unipolar_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pending[K_BPV]) || $rose(pending[K_EXZ])) |-> !$past(unipolar));
    // R6
    frm_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending[K_FRM]) |-> (frm_kind == $past(frm_sel)));
endmodule

bind err_req_ctrl err_req_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .err_en(err_en), .man_mode(man_mode),
    .e3_mode(e3_mode), .cbit_on(cbit_on), .unipolar(unipolar),
    .frm_sel(frm_sel), .opp(opp), .pending(pending), .frm_kind(frm_kind)
);

// File: tb/test_err_req_ctrl.sv
// Bench for err_req_ctrl: mode sweeps, manual mask sweep, merge, framing type.
module test_err_req_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] err_en = '0;
    logic       man_mode = 1'b0;
    logic       man_strobe = 1'b0;
    logic       e3_mode = 1'b0;
    logic       cbit_on = 1'b1;
    logic       unipolar = 1'b0;
    logic [1:0] frm_sel = '0;
    logic [4:0] opp = '0;
    logic [4:0] pending;
    logic [4:0] fire;
    logic [1:0] frm_kind;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    err_req_ctrl i_err_req_ctrl (
        .clk(clk), .rst_n(rst_n), .err_en(err_en), .man_mode(man_mode),
        .man_strobe(man_strobe), .e3_mode(e3_mode), .cbit_on(cbit_on),
        .unipolar(unipolar), .frm_sel(frm_sel), .opp(opp),
        .pending(pending), .fire(fire), .frm_kind(frm_kind)
    );

    function automatic logic [4:0] permit_mask(bit e3, bit cb, bit uni);
        logic [4:0] m = 5'b11111;
        if (uni) m[1:0] = 2'b00;
        if (e3)  m[3:2] = 2'b00;
        if (!cb) m[3] = 1'b0;
        return m;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic drive_edge();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        drive_edge(); rst_n = 1'b1;
        tick();
        chk("reset pending", pending, 0);
        chk("reset fire", fire, 0);
        chk("reset frm_kind", frm_kind, 0);

        // Automatic mode: every kind over every mode combination (R1 R2 R4 R7 R8 R9).
        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int k = 0; k < 5; k++) begin
                logic [4:0] pm;
                logic exp;
                drive_edge();
                e3_mode = cfg[0]; cbit_on = cfg[1]; unipolar = cfg[2];
                pm = permit_mask(cfg[0], cfg[1], cfg[2]);
                exp = pm[k];
                err_en[k] = 1'b1;
                tick();
                chk("R1 R7 R8 R9 arm on rise", pending, {4'b0, exp} << k);
                repeat (3) tick();
                chk("R2 R4 held high no rearm, still pending", pending, {4'b0, exp} << k);
                drive_edge(); opp[k] = 1'b1; #1;
                chk("R4 fire with opportunity", fire, {4'b0, exp} << k);
                tick();
                drive_edge(); opp[k] = 1'b0;
                repeat (2) tick();
                chk("R2 no rearm after clear while bit high", pending, 0);
                drive_edge(); err_en[k] = 1'b0;
                tick();
            end
        end
        drive_edge(); e3_mode = 0; cbit_on = 1; unipolar = 0;

        // Re-arm after clear-and-set (R2).
        drive_edge(); err_en[0] = 1; tick();
        drive_edge(); opp[0] = 1; tick();
        drive_edge(); opp[0] = 0; err_en[0] = 0; tick();
        drive_edge(); err_en[0] = 1; tick();
        chk("R2 clear then set rearms", pending, 5'b00001);
        drive_edge(); opp[0] = 1; tick();
        drive_edge(); opp[0] = 0; err_en[0] = 0; tick();

        // Manual mode: every enable mask, both strobe edges (R3).
        drive_edge(); man_mode = 1;
        for (int m = 0; m < 32; m++) begin
            drive_edge(); err_en = m[4:0]; man_strobe = ~man_strobe;
            tick(); tick();
            chk("R3 not yet armed at second edge", pending, 0);
            tick();
            chk("R3 toggle arms enabled kinds", pending, m[4:0]);
            drive_edge(); opp = 5'b11111; tick();
            drive_edge(); opp = '0; tick();
            chk("R3 single shot per toggle", pending, 0);
        end
        // Enable edges in manual mode arm nothing (R3).
        drive_edge(); err_en = 0; tick();
        drive_edge(); err_en = 5'b11111; repeat (4) tick();
        chk("R3 enable rise ignored in manual", pending, 0);
        // Manual toggle with unipolar and E3 gating (R9 R7).
        drive_edge(); unipolar = 1; e3_mode = 1; man_strobe = ~man_strobe;
        repeat (3) tick();
        chk("R7 R9 manual gated", pending, 5'b10000);
        drive_edge(); opp = 5'b11111; tick();
        drive_edge(); opp = 0; unipolar = 0; e3_mode = 0; err_en = 0; man_mode = 0; tick();

        // Merge: re-arm while pending (R5).
        drive_edge(); err_en[1] = 1; tick();
        drive_edge(); err_en[1] = 0; tick();
        drive_edge(); err_en[1] = 1; tick();
        chk("R5 merged still pending", pending, 5'b00010);
        drive_edge(); opp[1] = 1; tick();
        drive_edge(); opp[1] = 0; repeat (2) tick();
        chk("R5 merged request cleared by one opportunity", pending, 0);
        drive_edge(); err_en[1] = 0; tick();

        // Framing type capture over all selector values (R6).
        for (int s = 0; s < 4; s++) begin
            drive_edge(); frm_sel = s[1:0]; err_en[4] = 1; tick();
            drive_edge(); frm_sel = ~s[1:0]; err_en[4] = 0; tick();
            chk("R6 captured framing type", frm_kind, s);
            chk("R6 framing pending", pending, 5'b10000);
            drive_edge(); opp[4] = 1; #1;
            chk("R6 framing fire", fire, 5'b10000);
            tick();
            drive_edge(); opp[4] = 0; tick();
            chk("R6 type held after fire", frm_kind, s);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule